// File: doc/BRIEF.md
# Serial Port Control and Status Registers

This block is the register file that sits between a CPU bus and a simple FIFO-based serial port. The bus side is byte wide: a write strobe, a read strobe, an address, write data and registered read data. The block holds the mode, bit-rate, control, FIFO-control and port registers, and a set of five status flags: transmit end, transmit data empty, break, receive data full and data ready. It drives the transmit and receive interrupt lines.

Writing the transmit data register sends the byte out on a valid/data pair. The receive side of the port reports its events to this block as single-cycle pulses: a trigger-level event, a data-ready event and a break event. The receive byte and the fill level come in as plain inputs. A read of the receive data offset returns the offered byte and emits a pop pulse to the FIFO. Status flags are cleared by writing zero to them. While transmit is enabled, a read of the status register sets the transmit flags again right after it returns them.

Top module: `sercsr_top`

## Requirements
- R1: After reset, reads return mode 0x00, bit rate 0xFF, control 0x20, FIFO control 0x00, port 0x00 and status 0x60, and irq_tx, irq_rx and tx_valid are low.
- R2: A write stores the value ANDed with a mask for its register: mode (0x00) with 0x7B, control (0x08) with 0xFA and port (0x20) with 0xF3. Bit rate (0x04) and FIFO control (0x18) take all eight bits.
- R3: A write to the line status offset 0x24 changes no register or flag. Reads of the transmit data offset 0x0C, of 0x24 and of any unmapped offset return 0x00.
- R4: A write to the transmit data offset 0x0C raises tx_valid for exactly one cycle in the next cycle, with tx_data equal to the written byte, and clears the transmit-data-empty flag.
- R5: The status register at 0x10 holds transmit end at bit 6, transmit data empty at bit 5, break at bit 4, receive data full at bit 1 and data ready at bit 0, with the other bits reading 0. A status write clears each flag whose written bit is 0 and leaves the flag unchanged where the written bit is 1.
- R6: A status read returns the flags as they were before the read. If control bit 5 is 1, the read then sets transmit end and transmit data empty.
- R7: A control write with bit 5 at 0 sets transmit end. irq_tx takes control bit 7 from the cycle after each control write.
- R8: rdf_evt sets receive data full, dr_evt sets data ready and brk_evt sets break. An rdf_evt while control bit 6 is 1 also raises irq_rx in the next cycle.
- R9: irq_rx drops after a control write with bit 6 at 0, or after a status write with bit 1 or bit 0 at 0. A status write of 0xFF leaves it high.
- R10: A read of 0x14 returns rx_byte and pulses rx_pop for one cycle alongside the read data. A read of 0x1C returns rx_level zero-extended.
- R11: Read data appears one cycle after the read strobe and holds its value while no read is made.
- R12: A receive or break event in the same cycle as a status write that clears that flag leaves the flag set. An rdf_evt with interrupts enabled keeps irq_rx high over a same-cycle status clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | 6 | Register byte offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| rx_byte | input | 8 | Byte at the head of the receive FIFO |
| rx_level | input | 5 | Receive FIFO fill level |
| rx_pop | output | 1 | Pop pulse to the receive FIFO |
| rdf_evt | input | 1 | Receive trigger level reached |
| dr_evt | input | 1 | Receive data ready event |
| brk_evt | input | 1 | Break detected |
| tx_valid | output | 1 | Transmit byte valid pulse |
| tx_data | output | 8 | Transmit byte |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rx | output | 1 | Receive interrupt |

## Verification
On every cycle the assertions check the one-to-one relations. A transmit write yields the pulse and byte, a control write sets irq_tx, and a control write with bit 6 clear drops irq_rx. A break event sets its flag, a status read with transmit enabled sets the transmit flags, and the read and pop timing holds. Only the bench scenarios can show the values seen through reads: the reset contents, the write masks, the clear-by-zero pattern over the five flags, the old-value-then-set order of the status read, and the priority of events over clears. These scenarios are compared against a cycle-level reference model, which also follows a long random stretch of mixed traffic.

// File: rtl/sercsr_pkg.sv
package sercsr_pkg;
  localparam int OFF_MODE  = 'h00;
  localparam int OFF_RATE  = 'h04;
  localparam int OFF_CTRL  = 'h08;
  localparam int OFF_TXD   = 'h0C;
  localparam int OFF_STAT  = 'h10;
  localparam int OFF_RXD   = 'h14;
  localparam int OFF_FIFO  = 'h18;
  localparam int OFF_LEVEL = 'h1C;
  localparam int OFF_PORT  = 'h20;
  localparam int OFF_LINE  = 'h24;

  localparam int ST_TEND = 6;
  localparam int ST_TDE  = 5;
  localparam int ST_BRK  = 4;
  localparam int ST_RDF  = 1;
  localparam int ST_DR   = 0;

  localparam int CT_TIE = 7;
  localparam int CT_RIE = 6;
  localparam int CT_TE  = 5;

  localparam logic [7:0] MASK_MODE = 8'h7B;
  localparam logic [7:0] MASK_CTRL = 8'hFA;
  localparam logic [7:0] MASK_PORT = 8'hF3;
  localparam logic [7:0] RST_RATE  = 8'hFF;
  localparam logic [7:0] RST_CTRL  = 8'h20;
endpackage

// File: rtl/sercsr_cfg.sv
module sercsr_cfg
  import sercsr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_mode,
  input  logic          wr_rate,
  input  logic          wr_ctrl,
  input  logic          wr_fifo,
  input  logic          wr_port,
  input  logic          wr_txd,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] mode_q,
  output logic [DW-1:0] rate_q,
  output logic [DW-1:0] ctrl_q,
  output logic [DW-1:0] fifo_q,
  output logic [DW-1:0] port_q,
  output logic          irq_tx,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= '0;
      rate_q   <= DW'(RST_RATE);
      ctrl_q   <= DW'(RST_CTRL);
      fifo_q   <= '0;
      port_q   <= '0;
      irq_tx   <= 1'b0;
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      tx_valid <= wr_txd;
      if (wr_txd)  tx_data <= wdata;
      if (wr_mode) mode_q  <= wdata & DW'(MASK_MODE);
      if (wr_rate) rate_q  <= wdata;
      if (wr_fifo) fifo_q  <= wdata;
      if (wr_port) port_q  <= wdata & DW'(MASK_PORT);
      if (wr_ctrl) begin
        ctrl_q <= wdata & DW'(MASK_CTRL);
        irq_tx <= wdata[CT_TIE];
      end
    end
  end

  a_r7_tx_irq_follows: assert property (@(posedge clk) disable iff (rst)
    wr_ctrl |=> irq_tx == $past(wdata[CT_TIE]));
  a_r2_port_mask: assert property (@(posedge clk) disable iff (rst)
    wr_port |=> (port_q & ~DW'(MASK_PORT)) == '0);
endmodule

// File: rtl/sercsr_flags.sv
module sercsr_flags
  import sercsr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_stat,
  input  logic          rd_stat,
  input  logic          wr_ctrl,
  input  logic          wr_txd,
  input  logic          keep_tend,
  input  logic          keep_tde,
  input  logic          keep_brk,
  input  logic          keep_rdf,
  input  logic          keep_dr,
  input  logic          new_te,
  input  logic          new_rie,
  input  logic          te_q,
  input  logic          rie_q,
  input  logic          rdf_evt,
  input  logic          dr_evt,
  input  logic          brk_evt,
  output logic [DW-1:0] status,
  output logic          irq_rx
);
  logic tend, tde, brk, rdf, dr;
  logic rd_set, st_rx_clr;

  assign rd_set    = rd_stat && te_q;
  assign st_rx_clr = wr_stat && (!keep_rdf || !keep_dr);

  always_comb begin
    status          = '0;
    status[ST_TEND] = tend;
    status[ST_TDE]  = tde;
    status[ST_BRK]  = brk;
    status[ST_RDF]  = rdf;
    status[ST_DR]   = dr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tend   <= 1'b1;
      tde    <= 1'b1;
      brk    <= 1'b0;
      rdf    <= 1'b0;
      dr     <= 1'b0;
      irq_rx <= 1'b0;
    end else begin
      if (wr_ctrl && !new_te)          tend <= 1'b1;
      else if (wr_stat && !keep_tend)  tend <= 1'b0;
      else if (rd_set)                 tend <= 1'b1;

      if (wr_txd)                      tde <= 1'b0;
      else if (wr_stat && !keep_tde)   tde <= 1'b0;
      else if (rd_set)                 tde <= 1'b1;

      if (brk_evt)                     brk <= 1'b1;
      else if (wr_stat && !keep_brk)   brk <= 1'b0;

      if (rdf_evt)                     rdf <= 1'b1;
      else if (wr_stat && !keep_rdf)   rdf <= 1'b0;

      if (dr_evt)                      dr <= 1'b1;
      else if (wr_stat && !keep_dr)    dr <= 1'b0;

      if (wr_ctrl && !new_rie)         irq_rx <= 1'b0;
      else if (rdf_evt && rie_q)       irq_rx <= 1'b1;
      else if (st_rx_clr)              irq_rx <= 1'b0;
    end
  end

  a_r8_break_sets: assert property (@(posedge clk) disable iff (rst)
    brk_evt |=> status[ST_BRK]);
  a_r9_rie_off_drops_irq: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && !new_rie) |=> !irq_rx);
  a_r6_read_rearms_tx: assert property (@(posedge clk) disable iff (rst)
    (rd_stat && te_q && !wr_stat && !wr_txd && !wr_ctrl) |=> (status[ST_TEND] && status[ST_TDE]));
  a_r4_txd_clears_tde: assert property (@(posedge clk) disable iff (rst)
    wr_txd |=> !status[ST_TDE]);
endmodule

// File: rtl/sercsr_rdport.sv
module sercsr_rdport
  import sercsr_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 6,
  parameter int LW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] mode_q,
  input  logic [DW-1:0] rate_q,
  input  logic [DW-1:0] ctrl_q,
  input  logic [DW-1:0] status,
  input  logic [DW-1:0] fifo_q,
  input  logic [DW-1:0] port_q,
  input  logic [DW-1:0] rx_byte,
  input  logic [LW-1:0] rx_level,
  output logic [DW-1:0] rdata,
  output logic          rx_pop
);
  logic [DW-1:0] sel;

  always_comb begin
    sel = '0;
    if (addr == AW'(OFF_MODE))  sel = mode_q;
    if (addr == AW'(OFF_RATE))  sel = rate_q;
    if (addr == AW'(OFF_CTRL))  sel = ctrl_q;
    if (addr == AW'(OFF_STAT))  sel = status;
    if (addr == AW'(OFF_RXD))   sel = rx_byte;
    if (addr == AW'(OFF_FIFO))  sel = fifo_q;
    if (addr == AW'(OFF_LEVEL)) sel = DW'(rx_level);
    if (addr == AW'(OFF_PORT))  sel = port_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rx_pop <= 1'b0;
    end else begin
      rx_pop <= rd_en && (addr == AW'(OFF_RXD));
      if (rd_en) rdata <= sel;
    end
  end

  a_r11_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
  a_r10_pop_with_data: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == AW'(OFF_RXD)) |=> (rx_pop && rdata == $past(rx_byte)));
endmodule

// File: rtl/sercsr_top.sv
module sercsr_top
  import sercsr_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 6,
  parameter int LW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] rx_byte,
  input  logic [LW-1:0] rx_level,
  output logic          rx_pop,
  input  logic          rdf_evt,
  input  logic          dr_evt,
  input  logic          brk_evt,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  output logic          irq_tx,
  output logic          irq_rx
);
  logic wr_mode, wr_rate, wr_ctrl, wr_txd, wr_stat, wr_fifo, wr_port, rd_stat;
  logic [DW-1:0] mode_q, rate_q, ctrl_q, fifo_q, port_q, status;

  assign wr_mode = wr_en && addr == AW'(OFF_MODE);
  assign wr_rate = wr_en && addr == AW'(OFF_RATE);
  assign wr_ctrl = wr_en && addr == AW'(OFF_CTRL);
  assign wr_txd  = wr_en && addr == AW'(OFF_TXD);
  assign wr_stat = wr_en && addr == AW'(OFF_STAT);
  assign wr_fifo = wr_en && addr == AW'(OFF_FIFO);
  assign wr_port = wr_en && addr == AW'(OFF_PORT);
  assign rd_stat = rd_en && addr == AW'(OFF_STAT);

  sercsr_cfg #(.DW(DW)) u_cfg (
    .clk(clk), .rst(rst),
    .wr_mode(wr_mode), .wr_rate(wr_rate), .wr_ctrl(wr_ctrl),
    .wr_fifo(wr_fifo), .wr_port(wr_port), .wr_txd(wr_txd),
    .wdata(wdata),
    .mode_q(mode_q), .rate_q(rate_q), .ctrl_q(ctrl_q),
    .fifo_q(fifo_q), .port_q(port_q),
    .irq_tx(irq_tx), .tx_valid(tx_valid), .tx_data(tx_data)
  );

  sercsr_flags #(.DW(DW)) u_flags (
    .clk(clk), .rst(rst),
    .wr_stat(wr_stat), .rd_stat(rd_stat), .wr_ctrl(wr_ctrl), .wr_txd(wr_txd),
    .keep_tend(wdata[ST_TEND]), .keep_tde(wdata[ST_TDE]), .keep_brk(wdata[ST_BRK]),
    .keep_rdf(wdata[ST_RDF]), .keep_dr(wdata[ST_DR]),
    .new_te(wdata[CT_TE]), .new_rie(wdata[CT_RIE]),
    .te_q(ctrl_q[CT_TE]), .rie_q(ctrl_q[CT_RIE]),
    .rdf_evt(rdf_evt), .dr_evt(dr_evt), .brk_evt(brk_evt),
    .status(status), .irq_rx(irq_rx)
  );

  sercsr_rdport #(.DW(DW), .AW(AW), .LW(LW)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr),
    .mode_q(mode_q), .rate_q(rate_q), .ctrl_q(ctrl_q), .status(status),
    .fifo_q(fifo_q), .port_q(port_q), .rx_byte(rx_byte), .rx_level(rx_level),
    .rdata(rdata), .rx_pop(rx_pop)
  );

  a_r4_tx_emit: assert property (@(posedge clk) disable iff (rst)
    wr_txd |=> (tx_valid && tx_data == $past(wdata)));
  a_r4_tx_single: assert property (@(posedge clk) disable iff (rst)
    !wr_txd |=> !tx_valid);
endmodule

// File: tb/sercsr_top_test.sv
module sercsr_top_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0, rx_byte = '0;
  logic [4:0] rx_level = '0;
  logic       rdf_evt = 1'b0, dr_evt = 1'b0, brk_evt = 1'b0;
  logic [7:0] rdata, tx_data;
  logic       rx_pop, tx_valid, irq_tx, irq_rx;

  int n_checks = 0;
  int n_fails  = 0;

  // reference model state
  logic [7:0] m_mode, m_rate, m_ctrl, m_fifo, m_port, m_rdata, m_txd;
  logic       m_tend, m_tde, m_brk, m_rdf, m_dr, m_irx, m_itx, m_txv, m_pop;

  always #5 clk = ~clk;

  sercsr_top uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rx_byte(rx_byte), .rx_level(rx_level),
    .rx_pop(rx_pop), .rdf_evt(rdf_evt), .dr_evt(dr_evt), .brk_evt(brk_evt),
    .tx_valid(tx_valid), .tx_data(tx_data), .irq_tx(irq_tx), .irq_rx(irq_rx)
  );

  function automatic logic [7:0] m_status();
    return {1'b0, m_tend, m_tde, m_brk, 2'b00, m_rdf, m_dr};
  endfunction

  task automatic m_reset();
    m_mode = 8'h00; m_rate = 8'hFF; m_ctrl = 8'h20; m_fifo = 8'h00; m_port = 8'h00;
    m_rdata = 8'h00; m_txd = 8'h00;
    m_tend = 1; m_tde = 1; m_brk = 0; m_rdf = 0; m_dr = 0;
    m_irx = 0; m_itx = 0; m_txv = 0; m_pop = 0;
  endtask

  task automatic m_step();
    logic wst, wct, rsd;
    logic [7:0] old_ctrl;
    wst = wr_en && addr == 6'h10;
    wct = wr_en && addr == 6'h08;
    rsd = rd_en && addr == 6'h10;
    old_ctrl = m_ctrl;
    if (rd_en) begin
      case (addr)
        6'h00: m_rdata = m_mode;
        6'h04: m_rdata = m_rate;
        6'h08: m_rdata = m_ctrl;
        6'h10: m_rdata = m_status();
        6'h14: m_rdata = rx_byte;
        6'h18: m_rdata = m_fifo;
        6'h1C: m_rdata = {3'b000, rx_level};
        6'h20: m_rdata = m_port;
        default: m_rdata = 8'h00;
      endcase
    end
    m_pop = rd_en && addr == 6'h14;
    m_txv = wr_en && addr == 6'h0C;
    if (m_txv) m_txd = wdata;
    if (rsd && old_ctrl[5]) begin m_tend = 1; m_tde = 1; end
    if (wst) begin
      if (!wdata[6]) m_tend = 0;
      if (!wdata[5]) m_tde = 0;
      if (!wdata[4]) m_brk = 0;
      if (!wdata[1]) m_rdf = 0;
      if (!wdata[0]) m_dr = 0;
      if (!wdata[1] || !wdata[0]) m_irx = 0;
    end
    if (m_txv) m_tde = 0;
    if (brk_evt) m_brk = 1;
    if (dr_evt) m_dr = 1;
    if (rdf_evt) begin
      m_rdf = 1;
      if (old_ctrl[6]) m_irx = 1;
    end
    if (wct) begin
      m_ctrl = wdata & 8'hFA;
      m_itx = wdata[7];
      if (!wdata[5]) m_tend = 1;
      if (!wdata[6]) m_irx = 0;
    end
    if (wr_en && addr == 6'h00) m_mode = wdata & 8'h7B;
    if (wr_en && addr == 6'h04) m_rate = wdata;
    if (wr_en && addr == 6'h18) m_fifo = wdata;
    if (wr_en && addr == 6'h20) m_port = wdata & 8'hF3;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one clock: model follows the edge, outputs compared away from it
  task automatic cyc();
    @(posedge clk);
    m_step();
    @(negedge clk);
    chk("R11 model", {rdata, tx_valid, tx_data, irq_tx, irq_rx, rx_pop},
        {m_rdata, m_txv, m_txd, m_itx, m_irx, m_pop});
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    wr_en = 1; addr = a; wdata = d;
    cyc();
    wr_en = 0;
  endtask

  task automatic rd(input logic [5:0] a);
    rd_en = 1; addr = a;
    cyc();
    rd_en = 0;
  endtask

  task automatic pulse(input logic r, input logic d, input logic b);
    rdf_evt = r; dr_evt = d; brk_evt = b;
    cyc();
    rdf_evt = 0; dr_evt = 0; brk_evt = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 outputs", {irq_tx, irq_rx, tx_valid}, 3'b000);
    rd(6'h00); chk("R1 mode", rdata, 8'h00);
    rd(6'h04); chk("R1 rate", rdata, 8'hFF);
    rd(6'h08); chk("R1 ctrl", rdata, 8'h20);
    rd(6'h18); chk("R1 fifo", rdata, 8'h00);
    rd(6'h20); chk("R1 port", rdata, 8'h00);
    rd(6'h10); chk("R1 status", rdata, 8'h60);
    // R2 write masks
    wr(6'h00, 8'hFF); rd(6'h00); chk("R2 mode", rdata, 8'h7B);
    wr(6'h08, 8'hFF); rd(6'h08); chk("R2 ctrl", rdata, 8'hFA);
    chk("R7 irq_tx high", irq_tx, 1'b1);
    wr(6'h20, 8'hFF); rd(6'h20); chk("R2 port", rdata, 8'hF3);
    wr(6'h04, 8'h3C); rd(6'h04); chk("R2 rate", rdata, 8'h3C);
    wr(6'h18, 8'hC2); rd(6'h18); chk("R2 fifo", rdata, 8'hC2);
    // R3 ignored write and zero reads
    wr(6'h24, 8'h55); rd(6'h24); chk("R3 line", rdata, 8'h00);
    rd(6'h0C); chk("R3 txd read", rdata, 8'h00);
    rd(6'h28); chk("R3 unmapped", rdata, 8'h00);
    rd(6'h10); chk("R3 status untouched", rdata, 8'h60);
    // R4 transmit
    wr(6'h0C, 8'hA5);
    chk("R4 tx_valid", tx_valid, 1'b1); chk("R4 tx_data", tx_data, 8'hA5);
    cyc(); chk("R4 single pulse", tx_valid, 1'b0);
    // R6 old value then rearm
    rd(6'h10); chk("R6 pre-read value", rdata, 8'h40);
    rd(6'h10); chk("R6 rearmed", rdata, 8'h60);
    // R5 clear by zero
    wr(6'h08, 8'h00); chk("R7 irq_tx low", irq_tx, 1'b0);
    pulse(1, 1, 1);
    chk("R8 no irq when disabled", irq_rx, 1'b0);
    rd(6'h10); chk("R8 flags set", rdata, 8'h73);
    wr(6'h10, 8'h6F); rd(6'h10); chk("R5 clear break only", rdata, 8'h63);
    wr(6'h10, 8'h00); rd(6'h10); chk("R5 clear all", rdata, 8'h00);
    wr(6'h08, 8'h00); rd(6'h10); chk("R7 tend set", rdata, 8'h40);
    // R8 / R9 receive interrupt
    wr(6'h08, 8'h40);
    pulse(1, 0, 0); chk("R8 irq_rx raised", irq_rx, 1'b1);
    wr(6'h10, 8'hFF); chk("R9 all-ones keeps irq", irq_rx, 1'b1);
    wr(6'h10, 8'hFE); chk("R9 dr clear drops irq", irq_rx, 1'b0);
    pulse(1, 0, 0); chk("R8 irq_rx again", irq_rx, 1'b1);
    wr(6'h08, 8'h00); chk("R9 ctrl clear drops irq", irq_rx, 1'b0);
    pulse(1, 0, 0); chk("R8 disabled no irq", irq_rx, 1'b0);
    wr(6'h08, 8'h40);
    pulse(1, 0, 0); chk("R8 irq re-raised", irq_rx, 1'b1);
    wr(6'h10, 8'hFD); chk("R9 rdf clear drops irq", irq_rx, 1'b0);
    // R12 event beats clear
    wr_en = 1; addr = 6'h10; wdata = 8'h00; rdf_evt = 1; brk_evt = 1;
    cyc();
    wr_en = 0; rdf_evt = 0; brk_evt = 0;
    chk("R12 irq kept", irq_rx, 1'b1);
    rd(6'h10); chk("R12 flags kept", rdata & 8'h12, 8'h12);
    // R10 receive data and level
    rx_byte = 8'h3C; rx_level = 5'd9;
    rd(6'h14); chk("R10 rx byte", rdata, 8'h3C); chk("R10 pop", rx_pop, 1'b1);
    cyc(); chk("R10 pop once", rx_pop, 1'b0);
    chk("R11 hold", rdata, 8'h3C);
    rd(6'h1C); chk("R10 level", rdata, 8'h09);
    // random traffic against the model
    for (int i = 0; i < 600; i++) begin
      int k;
      k = $urandom_range(0, 9);
      addr = 6'(k * 4);
      wr_en = ($urandom_range(0, 2) == 0);
      rd_en = ($urandom_range(0, 2) == 0);
      wdata = 8'($urandom);
      rx_byte = 8'($urandom);
      rx_level = 5'($urandom_range(0, 16));
      rdf_evt = ($urandom_range(0, 5) == 0);
      dr_evt = ($urandom_range(0, 5) == 0);
      brk_evt = ($urandom_range(0, 9) == 0);
      cyc();
    end
    wr_en = 0; rd_en = 0; rdf_evt = 0; dr_evt = 0; brk_evt = 0;
    cyc();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule